// File: doc/BRIEF.md
# Channel synthesizer digital core

This block holds the digital part of a channel frequency synthesizer loop. Two square-wave inputs arrive as levels sampled by the system clock. One is the reference oscillator. The other is the down-mixed VCO signal. Each input passes through a two-register sampler, and a rising edge counts as one input cycle. The reference edges feed a fixed divider whose ratio depends on a step-select pin. The VCO edges feed a programmable divide-by-N counter whose N is taken from nine static binary pins.

A two-flip-flop phase/frequency comparator watches the two divided pulse trains. It raises a pump-up request when the reference leads and a pump-down request when the divided VCO leads. These requests steer an external charge pump and loop filter. A lock detector watches how wide the pump requests are. It reports lock once the loop has stayed tight for a run of comparison periods.

Top module: `pll_core`

## Requirements
- R1: A rising edge on an input is an input sample of 1 that follows a sample of 0. With `step_sel` high, `ref_div_pulse` gives a one-clock pulse once every REF_DIV reference rising edges (default 1024). With `step_sel` low, it gives one every 2*REF_DIV edges.
- R2: N is the unsigned value of `prog`, where bit i has weight 2^i (bit 0 weight 1 up to bit 8 weight 256, maximum 511). `vco_div_pulse` gives a one-clock pulse once every N VCO rising edges.
- R3: A `prog` value of 0 or 1 is clamped, so the divider divides by 2.
- R4: A change on `prog` is taken in only at a terminal count of the programmable divider. The division already running completes with the old N.
- R5: One clock after a `ref_div_pulse`, `pump_up` goes high. One clock after a `vco_div_pulse`, `pump_dn` goes high. A request stays high until the other side's pulse arrives.
- R6: When the set pulses would leave both requests high, both clear in the same clock. Coincident divided pulses leave both low. `pump_up` and `pump_dn` are never high together.
- R7: `lock_det` rises at the LOCK_PERIODS-th consecutive `ref_div_pulse` (default 16) with no violation. A violation is a pump request that stays high for more than `lock_win` clocks. A violation drops `lock_det` on the next clock and restarts the count.
- R8: A synchronous active-high `rst` clears both dividers, the samplers and the comparator, and forces `lock_det` low. During reset, N is loaded from `prog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference oscillator level |
| vco_in | input | 1 | Down-mixed VCO level |
| step_sel | input | 1 | 1 = fine step (REF_DIV), 0 = coarse step (2*REF_DIV) |
| prog | input | 9 | Binary divide ratio N |
| lock_win | input | 4 | Longest pump pulse, in clocks, still counted as tight |
| pump_up | output | 1 | Raise-VCO request |
| pump_dn | output | 1 | Lower-VCO request |
| lock_det | output | 1 | 1 = loop locked |
| ref_div_pulse | output | 1 | Divided reference pulse |
| vco_div_pulse | output | 1 | Divided VCO pulse |

## Verification
The first pattern has both inputs toggling together with N matched to the reference ratio, in fine and in coarse step. This shows that the pulse trains coincide, the pumps stay quiet and lock forms. Next, N is retuned to a slower value so that the reference leads. This separates correct request setting and pulse-width measurement from a detector that never drops lock. Large, clamped and mid-division N changes are measured by the gap between divided pulses. A behavioural model also tracks every output on every clock.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
  localparam int unsigned PROG_W = 9;
  localparam int unsigned MIN_N  = 2;

  // reference division ratio for the selected step
  function automatic int unsigned ref_ratio(input logic fine, input int unsigned base);
    return fine ? base : 2 * base;
  endfunction

  // N values below MIN_N are not usable
  function automatic int unsigned clamp_div(input int unsigned n);
    return (n < MIN_N) ? MIN_N : n;
  endfunction
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int unsigned REF_DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic step_sel,
  output logic tc
);
  import pll_core_pkg::*;
  localparam int unsigned CW = $clog2(2 * REF_DIV);

  logic [1:0]    smp;
  logic [CW-1:0] cnt;
  logic          rise;
  int unsigned   ratio;

  assign rise  = smp[0] & ~smp[1];
  assign ratio = ref_ratio(step_sel, REF_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp <= '0;
      cnt <= '0;
      tc  <= 1'b0;
    end else begin
      smp <= {smp[0], ref_in};
      tc  <= 1'b0;
      if (rise) begin
        if (32'(cnt) >= ratio - 1) begin
          cnt <= '0;
          tc  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
  parameter int unsigned PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vco_in,
  input  logic [PW-1:0] prog,
  output logic          wrap,
  output logic [PW-1:0] n_act,
  output logic          tc
);
  import pll_core_pkg::*;

  logic [1:0]    smp;
  logic [PW-1:0] cnt;
  logic [PW-1:0] n_next;
  logic          rise;

  assign rise   = smp[0] & ~smp[1];
  assign n_next = PW'(clamp_div(32'(prog)));
  assign wrap   = rise && (cnt >= n_act - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= '0;
      cnt   <= '0;
      n_act <= n_next;
      tc    <= 1'b0;
    end else begin
      smp <= {smp[0], vco_in};
      tc  <= 1'b0;
      if (wrap) begin
        cnt   <= '0;
        tc    <= 1'b1;
        n_act <= n_next;
      end else if (rise) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst,
  input  logic set_up,
  input  logic set_dn,
  output logic up,
  output logic dn
);
  logic nu, nd;
  assign nu = up | set_up;
  assign nd = dn | set_dn;

  always_ff @(posedge clk) begin
    if (rst || (nu && nd)) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= nu;
      dn <= nd;
    end
  end
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned WIN_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             period_mark,
  input  logic [WIN_W-1:0] win,
  output logic             viol,
  output logic             locked
);
  localparam int unsigned GW = (LOCK_PERIODS > 1) ? $clog2(LOCK_PERIODS) : 1;

  logic [WIN_W-1:0] width;
  logic [GW-1:0]    good;

  assign viol = active && (width >= win);

  always_ff @(posedge clk) begin
    if (rst) begin
      width  <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else begin
      if (!active)       width <= '0;
      else if (~&width)  width <= width + 1'b1;
      if (viol) begin
        good   <= '0;
        locked <= 1'b0;
      end else if (period_mark) begin
        if (good == GW'(LOCK_PERIODS - 1)) locked <= 1'b1;
        else                               good   <= good + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_core.sv
module pll_core #(
  parameter int unsigned REF_DIV      = 1024,
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned WIN_W        = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ref_in,
  input  logic                              vco_in,
  input  logic                              step_sel,
  input  logic [pll_core_pkg::PROG_W-1:0]   prog,
  input  logic [WIN_W-1:0]                  lock_win,
  output logic                              pump_up,
  output logic                              pump_dn,
  output logic                              lock_det,
  output logic                              ref_div_pulse,
  output logic                              vco_div_pulse
);
  import pll_core_pkg::*;

  // internal events, named for the checker
  logic              prog_wrap;
  logic [PROG_W-1:0] n_act;
  logic              width_viol;

  pll_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk(clk), .rst(rst), .ref_in(ref_in), .step_sel(step_sel), .tc(ref_div_pulse));

  pll_prog_div #(.PW(PROG_W)) u_prog (
    .clk(clk), .rst(rst), .vco_in(vco_in), .prog(prog),
    .wrap(prog_wrap), .n_act(n_act), .tc(vco_div_pulse));

  pll_pfd u_pfd (
    .clk(clk), .rst(rst), .set_up(ref_div_pulse), .set_dn(vco_div_pulse),
    .up(pump_up), .dn(pump_dn));

  pll_lock_det #(.LOCK_PERIODS(LOCK_PERIODS), .WIN_W(WIN_W)) u_lock (
    .clk(clk), .rst(rst), .active(pump_up | pump_dn), .period_mark(ref_div_pulse),
    .win(lock_win), .viol(width_viol), .locked(lock_det));
endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk #(
  parameter int unsigned PW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          up,
  input logic          dn,
  input logic          lock,
  input logic          ref_tc,
  input logic          prog_tc,
  input logic          prog_wrap,
  input logic          viol,
  input logic [PW-1:0] n_act
);
  p_excl_r6: assert property (@(posedge clk) disable iff (rst) !(up && dn));
  p_up_set_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_tc && !prog_tc && !dn) |=> up);
  p_dn_set_r5: assert property (@(posedge clk) disable iff (rst)
    (prog_tc && !ref_tc && !up) |=> dn);
  p_both_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_tc && prog_tc) |=> (!up && !dn));
  p_viol_unlock_r7: assert property (@(posedge clk) disable iff (rst) viol |=> !lock);
  p_lock_on_mark_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(ref_tc));
  p_hold_n_r4: assert property (@(posedge clk) disable iff (rst)
    !prog_wrap |=> $stable(n_act));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!up && !dn && !lock && !ref_tc && !prog_tc));
endmodule

bind pll_core pll_core_chk #(.PW(pll_core_pkg::PROG_W)) u_chk (
  .clk(clk), .rst(rst), .up(pump_up), .dn(pump_dn), .lock(lock_det),
  .ref_tc(ref_div_pulse), .prog_tc(vco_div_pulse), .prog_wrap(prog_wrap),
  .viol(width_viol), .n_act(n_act));

// File: tb/pll_core_test.sv
module pll_core_test;
  localparam int RD = 16;
  localparam int LP = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0, vco_in = 1'b0, step_sel = 1'b1;
  logic [8:0] prog = 9'd16;
  logic [3:0] lock_win = 4'd3;
  logic       pump_up, pump_dn, lock_det, ref_div_pulse, vco_div_pulse;

  int checks = 0, errors = 0;
  int rhalf = 1, vhalf = 1;

  always #10 clk = ~clk;

  pll_core #(.REF_DIV(RD), .LOCK_PERIODS(LP), .WIN_W(4)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .vco_in(vco_in), .step_sel(step_sel),
    .prog(prog), .lock_win(lock_win), .pump_up(pump_up), .pump_dn(pump_dn),
    .lock_det(lock_det), .ref_div_pulse(ref_div_pulse), .vco_div_pulse(vco_div_pulse));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus generators, phases restart in reset
  int rph = 0, vph = 0;
  always @(negedge clk) begin
    if (rst) begin
      ref_in = 1'b0; vco_in = 1'b0; rph = 0; vph = 0;
    end else begin
      if (rph >= rhalf - 1) begin ref_in = ~ref_in; rph = 0; end else rph++;
      if (vph >= vhalf - 1) begin vco_in = ~vco_in; vph = 0; end else vph++;
    end
  end

  // behavioural reference model, advanced on each rising edge
  function automatic int eff_n(input int n);
    if (n < 2) return 2;
    return n;
  endfunction

  int r_hist[$], v_hist[$];
  int m_rc, m_pc, m_n, m_rtc, m_ptc, m_up, m_dn, m_w, m_g, m_lk;
  always @(posedge clk) begin
    if (rst) begin
      r_hist = {0, 0}; v_hist = {0, 0};
      m_rc = 0; m_pc = 0; m_n = eff_n(int'(prog)); m_rtc = 0; m_ptc = 0;
      m_up = 0; m_dn = 0; m_w = 0; m_g = 0; m_lk = 0;
    end else begin
      int rr, vr, ratio, su, sd, act, viol;
      int n_rc, n_pc, n_n, n_rtc, n_ptc, n_up, n_dn, n_w, n_g, n_lk;
      rr = (r_hist[0] == 1 && r_hist[1] == 0);
      vr = (v_hist[0] == 1 && v_hist[1] == 0);
      ratio = step_sel ? RD : 2 * RD;
      n_rc = m_rc; n_rtc = 0;
      if (rr) begin
        if (m_rc + 1 >= ratio) begin n_rc = 0; n_rtc = 1; end else n_rc = m_rc + 1;
      end
      n_pc = m_pc; n_ptc = 0; n_n = m_n;
      if (vr) begin
        if (m_pc + 1 >= m_n) begin n_pc = 0; n_ptc = 1; n_n = eff_n(int'(prog)); end
        else n_pc = m_pc + 1;
      end
      su = m_up | m_rtc; sd = m_dn | m_ptc;
      n_up = (su && sd) ? 0 : su;
      n_dn = (su && sd) ? 0 : sd;
      act = m_up | m_dn;
      viol = act && (m_w >= int'(lock_win));
      n_w = act ? ((m_w < 15) ? m_w + 1 : 15) : 0;
      n_g = m_g; n_lk = m_lk;
      if (viol) begin n_g = 0; n_lk = 0; end
      else if (m_rtc) begin
        if (m_g == LP - 1) n_lk = 1; else n_g = m_g + 1;
      end
      m_rc = n_rc; m_pc = n_pc; m_n = n_n; m_rtc = n_rtc; m_ptc = n_ptc;
      m_up = n_up; m_dn = n_dn; m_w = n_w; m_g = n_g; m_lk = n_lk;
      r_hist.push_front(int'(ref_in)); void'(r_hist.pop_back());
      v_hist.push_front(int'(vco_in)); void'(v_hist.pop_back());
    end
  end

  // per-clock comparison plus pulse-gap monitors
  int cyc = 0, rlast = 0, vlast = 0, rgap = 0, vgap = 0, rcount = 0, vcount = 0, upcyc = 0;
  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (cmp_on && !rst) begin
      check("R1 ref_div_pulse vs model", int'(ref_div_pulse), m_rtc);
      check("R2 vco_div_pulse vs model", int'(vco_div_pulse), m_ptc);
      check("R5 pump_up vs model", int'(pump_up), m_up);
      check("R5 pump_dn vs model", int'(pump_dn), m_dn);
      check("R7 lock_det vs model", int'(lock_det), m_lk);
      if (pump_up && pump_dn) check("R6 pumps exclusive", 1, 0);
    end
    if (pump_up) upcyc++;
    if (ref_div_pulse) begin rgap = cyc - rlast; rlast = cyc; rcount++; end
    if (vco_div_pulse) begin vgap = cyc - vlast; vlast = cyc; vcount++; end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cycles(3);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_v(input int k);
    int n0 = vcount;
    while (vcount < n0 + k) @(posedge clk);
  endtask

  task automatic wait_r(input int k);
    int n0 = rcount;
    while (rcount < n0 + k) @(posedge clk);
  endtask

  initial begin
    cycles(3);
    #1;
    // R8 reset state
    check("R8 pump_up in reset", int'(pump_up), 0);
    check("R8 pump_dn in reset", int'(pump_dn), 0);
    check("R8 lock_det in reset", int'(lock_det), 0);
    @(negedge clk); rst = 1'b0; cmp_on = 1'b1;

    // R1 R7 fine step, matched N: lock forms
    cycles(700);
    check("R1 fine ref gap", rgap, 2 * RD);
    check("R7 lock after matched run", int'(lock_det), 1);
    check("R6 no pump activity when aligned", upcyc, 0);

    // R4 R7 retune to a slower N while locked: lock drops
    @(negedge clk); prog = 9'd17;
    cycles(400);
    check("R7 lock lost after retune", int'(lock_det), 0);
    check("R5 pump_up seen when reference leads", int'(upcyc > 0), 1);

    // R1 coarse step, N = 32
    @(negedge clk); step_sel = 1'b0; prog = 9'd32;
    do_reset();
    cycles(1200);
    check("R1 coarse ref gap", rgap, 4 * RD);
    check("R7 lock in coarse step", int'(lock_det), 1);

    // R2 large N = 330 (bits 1,3,6,8)
    @(negedge clk); step_sel = 1'b1; prog = 9'b101001010;
    do_reset();
    wait_v(2);
    check("R2 gap for N=330", vgap, 660);

    // R3 clamp of 0 and 1
    @(negedge clk); prog = 9'd0;
    do_reset();
    wait_v(3);
    check("R3 gap for N=0", vgap, 4);
    @(negedge clk); prog = 9'd1;
    do_reset();
    wait_v(3);
    check("R3 gap for N=1", vgap, 4);

    // R4 mid-division change
    @(negedge clk); prog = 9'd16;
    do_reset();
    wait_v(1);
    cycles(10);
    @(negedge clk); prog = 9'd20;
    wait_v(1);
    check("R4 running division keeps old N", vgap, 32);
    wait_v(1);
    check("R4 new N after terminal count", vgap, 40);

    // R2 R7 slow VCO never locks, pulse widths grow
    @(negedge clk); prog = 9'd8; vhalf = 3;
    do_reset();
    wait_r(20);
    check("R2 gap for N=8 slow input", vgap, 48);
    check("R7 no lock with drifting phase", int'(lock_det), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule